// File: doc/BRIEF.md
# Random-Latency Release Stage

This block sits behind an operation unit whose completion time depends on its operands or on the operation chosen, and it hides that dependence. When a start pulse is accepted, the stage waits a fixed number of cycles equal to the slowest possible evaluation of the guarded unit. It then waits an extra number of cycles picked by a random word. Only then does it copy the unit's result bus into a hold register and raise a valid flag. The moment the result appears therefore carries no information about how long the computation really took.

The random part is built from a chain of taps. Tap k either inserts a wait of 2^k cycles or lets the release event through in the same cycle, under one bit of the random word. That word is taken once per accepted start. A start that arrives while a release is pending is ignored, and a busy output shows that window. Several stages can be placed one after another, one per level of a pipeline, each fed by its own random source, so that every level has its own random release point.

Top module: `rlr_release_stage`

## Requirements
- R1: While reset is held and straight after it, `busy_o` and `valid_o` are 0 and `data_o` is all zeros.
- R2: A start pulse seen while `busy_o` is low is accepted. At the next clock edge `busy_o` goes to 1 and `valid_o` goes to 0.
- R3: `valid_o` rises exactly `EVAL_CYC + sel` clock edges after the edge that accepted the start. Here `sel` is `rnd_i` sampled at that edge, read as an unsigned number: bit k adds 2^k cycles when it is 1 and nothing when it is 0.
- R4: `data_o` takes the value `result_i` holds in the cycle just before `valid_o` rises. Values `result_i` had at start time or earlier are not captured.
- R5: No release comes sooner than `EVAL_CYC` edges after acceptance. With `rnd_i` all zeros the latency is exactly `EVAL_CYC`.
- R6: A start pulse while `busy_o` is high is ignored. The pending release keeps its latency and does not take the new `rnd_i`.
- R7: Once `valid_o` is high, it and `data_o` stay unchanged whatever `result_i` does, until the next accepted start.
- R8: `busy_o` and `valid_o` are never 1 at the same time. `busy_o` falls at the same edge at which `valid_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start of a new operation, one cycle pulse |
| result_i | input | DATA_W | Result bus of the guarded operation unit |
| rnd_i | input | SEL_BITS | Random word; bit k selects a 2^k-cycle extra wait |
| busy_o | output | 1 | A release is pending |
| valid_o | output | 1 | `data_o` holds a released result |
| data_o | output | DATA_W | Held result |

## Verification
The bench builds the stage with `DATA_W=16`, `EVAL_CYC=3` and `SEL_BITS=3`. With these values all eight tap patterns can be run, so every latency from 3 to 10 cycles is measured, including the bypass-only chain at the lower limit and the all-taps-delayed chain at the upper one. A fixed wait of three cycles leaves room to change `result_i` after the start and to pulse start again while the release is pending, which is how capture timing and the ignored start are checked.

// File: rtl/rlr_pkg.sv
package rlr_pkg;

  // Extra wait contributed by tap number k of the random chain.
  function automatic int unsigned rlr_tap_weight(input int unsigned k);
    return 32'd1 << k;
  endfunction

  // Total wait from the accepting edge to the release edge.
  function automatic int unsigned rlr_latency(input int unsigned base,
                                              input int unsigned sel);
    return base + sel;
  endfunction

  // Largest wait that the chain can produce.
  function automatic int unsigned rlr_max_latency(input int unsigned base,
                                                  input int unsigned bits);
    return base + (32'd1 << bits) - 32'd1;
  endfunction

endpackage

// File: rtl/rlr_fixed_wait.sv
// Worst-case evaluation wait: emits a one-cycle event so that the
// consumer acts on the edge WAIT_CYC edges after go_i was sampled.
module rlr_fixed_wait #(
  parameter int unsigned WAIT_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic ev_o
);
  localparam int unsigned CW = $clog2(WAIT_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (go_i)            cnt_q <= CW'(WAIT_CYC);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign ev_o = (cnt_q == CW'(1));

  // R6: the owner never restarts the wait while it is running
  p_no_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> !go_i);

  // R5: an event is always preceded by a full wait
  p_wait_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |=> !ev_o || (WAIT_CYC == 1));

endmodule

// File: rtl/rlr_tap_stage.sv
// One tap of the random chain: delay the event by WEIGHT cycles when
// sel_i is set, or pass it on in the same cycle when it is clear.
module rlr_tap_stage #(
  parameter int unsigned WEIGHT = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic ev_i,
  output logic ev_o
);
  localparam int unsigned CW = $clog2(WEIGHT + 1);

  logic [CW-1:0] cnt_q;
  logic          delayed_ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (ev_i && sel_i)      cnt_q <= CW'(WEIGHT);
    else if (cnt_q != '0)        cnt_q <= cnt_q - CW'(1);
  end

  assign delayed_ev = (cnt_q == CW'(1));

  generate
    if (WEIGHT == 0) begin : g_wire
      assign ev_o = ev_i;
    end else begin : g_mux
      assign ev_o = sel_i ? delayed_ev : ev_i;
    end
  endgenerate

  // R6: no second event enters a tap that is still counting
  p_no_rearm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> !ev_i);

  // R3: a bypassed tap never holds a count of its own
  p_bypass_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i && ev_i) |=> (cnt_q == '0));

endmodule

// File: rtl/rlr_hold_reg.sv
// Result hold register: cleared-valid on a new start, loaded on release.
module rlr_hold_reg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] d_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] q_o
);
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (cap_i) begin
      valid_q <= 1'b1;
      data_q  <= d_i;
    end else if (clr_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign q_o     = data_q;

  // R7: a released result stays put until a new start
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !clr_i && !cap_i) |=> valid_q && $stable(data_q));

  // R4: capture loads the bus value of the release cycle
  p_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> valid_q && (data_q == $past(d_i)));

endmodule

// File: rtl/rlr_release_stage.sv
// Random-latency release stage: fixed worst-case wait, then a chain of
// binary-weighted taps, then a hold register loaded on the release edge.
module rlr_release_stage #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned EVAL_CYC = 4,
  parameter int unsigned SEL_BITS = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [DATA_W-1:0]   result_i,
  input  logic [SEL_BITS-1:0] rnd_i,
  output logic                busy_o,
  output logic                valid_o,
  output logic [DATA_W-1:0]   data_o
);
  import rlr_pkg::*;

  localparam int unsigned MAX_LAT = rlr_max_latency(EVAL_CYC, SEL_BITS);
  localparam int unsigned EW      = $clog2(MAX_LAT + 2);

  // named internal events
  logic                accept_ev;
  logic                release_ev;
  logic [SEL_BITS:0]   chain_ev;
  logic                busy_q;
  logic [SEL_BITS-1:0] sel_q;

  assign accept_ev = start_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sel_q  <= '0;
    end else begin
      if (accept_ev) begin
        busy_q <= 1'b1;
        sel_q  <= rnd_i;
      end else if (release_ev) begin
        busy_q <= 1'b0;
      end
    end
  end

  rlr_fixed_wait #(
    .WAIT_CYC(EVAL_CYC)
  ) u_fixed (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (accept_ev),
    .ev_o   (chain_ev[0])
  );

  generate
    for (genvar k = 0; k < SEL_BITS; k++) begin : g_tap
      rlr_tap_stage #(
        .WEIGHT(rlr_tap_weight(k))
      ) u_tap (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sel_i  (sel_q[k]),
        .ev_i   (chain_ev[k]),
        .ev_o   (chain_ev[k+1])
      );
    end
  endgenerate

  assign release_ev = chain_ev[SEL_BITS];

  rlr_hold_reg #(
    .DATA_W(DATA_W)
  ) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept_ev),
    .cap_i   (release_ev),
    .d_i     (result_i),
    .valid_o (valid_o),
    .q_o     (data_o)
  );

  assign busy_o = busy_q;

  // ---- checker state: cycles elapsed since the accepting edge ----
  logic [EW-1:0] elapsed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      elapsed_q <= '0;
    else if (accept_ev)               elapsed_q <= EW'(1);
    else if (busy_q && !release_ev)   elapsed_q <= elapsed_q + EW'(1);
  end

  // R3: release lands exactly base plus selected weights after acceptance
  p_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_ev |-> (32'(elapsed_q) == rlr_latency(EVAL_CYC, 32'(sel_q))));

  // R5: never earlier than the worst-case evaluation time
  p_min_wait_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_ev |-> (32'(elapsed_q) >= EVAL_CYC));

  // R2: acceptance raises busy and drops valid
  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_ev |=> busy_o && !valid_o);

  // R6: the random select is frozen while a release is pending
  p_sel_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(sel_q));

  // R8: busy and valid exclusive, and release only while busy
  p_exclusive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && valid_o));
  p_release_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_ev |-> busy_q ##1 (!busy_o && valid_o));

  // R8: at most one event travels the chain at a time
  p_one_event_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({accept_ev, release_ev}));

endmodule

// File: tb/sim_rlr_release_stage.sv
`timescale 1ns/1ps
module sim_rlr_release_stage;
  localparam int unsigned DW  = 16;
  localparam int unsigned EC  = 3;
  localparam int unsigned SB  = 3;
  localparam int          NV  = 8;

  localparam logic [SB-1:0] V_RND [NV] = '{3'd5, 3'd0, 3'd7, 3'd2, 3'd1, 3'd6, 3'd3, 3'd4};
  localparam logic [DW-1:0] V_DAT [NV] = '{16'hA5C3, 16'h1234, 16'hFFFF, 16'h1234,
                                           16'h0001, 16'h8000, 16'h1234, 16'h5A5A};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [DW-1:0] result = '0;
  logic [SB-1:0] rnd = '0;
  logic          busy, valid;
  logic [DW-1:0] data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  rlr_release_stage #(.DATA_W(DW), .EVAL_CYC(EC), .SEL_BITS(SB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .result_i(result),
    .rnd_i(rnd), .busy_o(busy), .valid_o(valid), .data_o(data)
  );

  // expected wait, summed tap by tap
  function automatic int exp_lat(input logic [SB-1:0] r);
    int s = EC;
    for (int k = 0; k < SB; k++) if (r[k]) s += (1 << k);
    return s;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Accept a start, count edges until valid; optional second start at edge 1.
  task automatic run_one(input logic [SB-1:0] r, input logic [DW-1:0] d,
                         input bit poke, output int lat);
    int n;
    @(negedge clk);
    start = 1'b1; rnd = r; result = ~d;
    @(negedge clk);
    start = 1'b0; result = d; rnd = ~r;
    check(busy === 1'b1, "R2 busy after accept", int'(busy), 1);
    check(valid === 1'b0, "R2 valid cleared", int'(valid), 0);
    n = 0;
    while (valid !== 1'b1 && n < 60) begin
      if (poke && n == 1) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    lat = n;
  endtask

  initial begin
    int lat;
    logic [DW-1:0] held;
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R1 busy in reset", int'(busy), 0);
    check(valid === 1'b0, "R1 valid in reset", int'(valid), 0);
    check(data === '0, "R1 data in reset", int'(data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && valid === 1'b0, "R1 idle after reset", int'({busy, valid}), 0);

    // table walk: every tap pattern, repeated data with different latencies
    for (int i = 0; i < NV; i++) begin
      run_one(V_RND[i], V_DAT[i], 1'b0, lat);
      check(lat == exp_lat(V_RND[i]), (V_RND[i] == 0) ? "R5 latency floor" : "R3 latency",
            lat, exp_lat(V_RND[i]));
      check(data === V_DAT[i], "R4 captured at release", int'(data), int'(V_DAT[i]));
      check(busy === 1'b0, "R8 busy low when valid", int'(busy), 0);
      repeat (2) @(negedge clk);
    end

    // R6: start during a pending release is ignored
    run_one(3'd2, 16'hBEEF, 1'b1, lat);
    check(lat == exp_lat(3'd2), "R6 pending latency kept", lat, exp_lat(3'd2));
    @(negedge clk);
    check(busy === 1'b0 && valid === 1'b1, "R6 no second release", int'({busy, valid}), 1);

    // R7: result held while the input bus moves
    held = data;
    for (int j = 0; j < 5; j++) begin
      result = 16'h0F0F + 16'(j);
      @(negedge clk);
    end
    check(valid === 1'b1 && data === held, "R7 held result", int'(data), int'(held));

    // R2: the next start drops valid
    run_one(3'd0, 16'h7777, 1'b0, lat);
    check(lat == EC, "R5 minimum wait", lat, EC);
    check(data === 16'h7777, "R4 final capture", int'(data), 16'h7777);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule